// File: doc/BRIEF.md
# Microcoded Multicycle Control Sequencer

This block steers a multicycle processor datapath from a small stored microprogram instead of a hand-built state machine. A microaddress register points at one of ten control words. Each word holds encoded datapath fields: ALU operation, the two ALU operand selects, register-file action, memory action and PC update. It also holds a 2-bit sequencing code. The fields are decoded into the individual strobe and select lines that the datapath uses during the current cycle.

The sequencing code picks the next microaddress from four sources: return to the fetch word, jump through the first opcode lookup table, jump through the second opcode lookup table, or step to the following word. The first table sends the instruction to its class routine right after decode. The second table splits the shared load/store address routine into its load and store tails. The 6-bit opcode comes from the instruction register, which the datapath holds for the whole instruction. Supported classes are register-register ALU operations, load word, store word, branch-if-equal and jump.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst_n` is low the microaddress is 0 (asynchronously). After release the first word executed is the fetch word at address 0.
- R2: Sequencing code 2'b11 advances the microaddress by one. The words at addresses 0, 3 and 6 use it, giving 0→1, 3→4 and 6→7.
- R3: At address 1 the next address comes from lookup table 1. Opcode 6'b000000 goes to 6, 6'b000010 to 9, 6'b000100 to 8, and both 6'b100011 and 6'b101011 go to 2.
- R4: At address 2 the next address comes from lookup table 2. Opcode 6'b100011 goes to 3 and 6'b101011 goes to 5.
- R5: The words at addresses 4, 5, 7, 8 and 9 carry sequencing code 2'b00 and return to address 0 on the next edge.
- R6: An opcode that is absent from the lookup table in use yields next address 0, in both table 1 and table 2.
- R7: Control outputs follow the current microaddress in the same cycle. Address 0 gives mem_read=1, iord=0, ir_write=1, pc_write=1, pc_source=2'b00, alu_src_a=0, alu_src_b=2'b01, alu_op=2'b00. Address 1 gives alu_src_a=0, alu_src_b=2'b11, alu_op=2'b00. Every other output is 0 in both words.
- R8: Memory-reference words. Address 2 gives alu_src_a=1, alu_src_b=2'b10, alu_op=2'b00. Address 3 gives mem_read=1, iord=1. Address 4 gives reg_write=1, reg_dst=0, mem_to_reg=1. Address 5 gives mem_write=1, iord=1. All other outputs are 0.
- R9: Register-register words. Address 6 gives alu_src_a=1, alu_src_b=2'b00, alu_op=2'b10. Address 7 gives reg_write=1, reg_dst=1, mem_to_reg=0. All other outputs are 0.
- R10: Control-flow words. Address 8 gives alu_src_a=1, alu_src_b=2'b00, alu_op=2'b01, pc_write_cond=1, pc_source=2'b01. Address 9 gives pc_write=1, pc_source=2'b10. All other outputs are 0.
- R11: The opcode has no effect on the next address at any microaddress other than 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronised to clk on release |
| opcode | input | 6 | Opcode field from the instruction register |
| uaddr | output | 4 | Current microaddress |
| pc_write | output | 1 | Unconditional PC load |
| pc_write_cond | output | 1 | PC load qualified by the ALU zero flag |
| pc_source | output | 2 | PC source: 00 ALU result, 01 ALU output register, 10 jump target |
| iord | output | 1 | Memory address select: 0 PC, 1 ALU output register |
| mem_read | output | 1 | Memory read strobe |
| mem_write | output | 1 | Memory write strobe |
| ir_write | output | 1 | Instruction register load |
| reg_write | output | 1 | Register file write |
| reg_dst | output | 1 | Destination register select: 1 rd, 0 rt |
| mem_to_reg | output | 1 | Write-back data select: 1 memory data register, 0 ALU output register |
| alu_src_a | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU B operand: 00 register B, 01 constant 4, 10 extended immediate, 11 shifted extended immediate |
| alu_op | output | 2 | ALU operation: 00 add, 01 subtract, 10 function code |

## Verification
The hardest case to reach from the ports is a miss in the second lookup table. With a steady opcode, address 2 is entered only for a load or a store, and both of those hit. The bench therefore runs a load through decode into address 2. It then changes the opcode to a branch value during that one cycle and expects the return to address 0. In the same spirit, it changes the opcode while the sequencer sits at non-dispatch addresses, which shows the opcode is ignored there.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;

  localparam int unsigned OP_W = 6;

  typedef enum logic [1:0] {
    SEQ_FETCH = 2'b00,
    SEQ_TBL1  = 2'b01,
    SEQ_TBL2  = 2'b10,
    SEQ_STEP  = 2'b11
  } seq_e;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_SUB  = 2'b01,
    ALU_FUNC = 2'b10
  } alu_e;

  typedef enum logic [1:0] {
    OPB_REGB  = 2'b00,
    OPB_FOUR  = 2'b01,
    OPB_IMM   = 2'b10,
    OPB_IMMSH = 2'b11
  } opb_e;

  typedef enum logic [1:0] {
    RF_IDLE  = 2'b00,
    RF_READ  = 2'b01,
    RF_WRALU = 2'b10,
    RF_WRMDR = 2'b11
  } rf_e;

  typedef enum logic [1:0] {
    MM_IDLE  = 2'b00,
    MM_RDPC  = 2'b01,
    MM_RDALU = 2'b10,
    MM_WRALU = 2'b11
  } mm_e;

  typedef enum logic [1:0] {
    PCU_HOLD = 2'b00,
    PCU_ALU  = 2'b01,
    PCU_COND = 2'b10,
    PCU_JUMP = 2'b11
  } pcu_e;

  typedef struct packed {
    alu_e alu;
    logic opa_reg;
    opb_e opb;
    rf_e  rf;
    mm_e  mm;
    pcu_e pcu;
    seq_e seq;
  } uword_t;

  localparam logic [OP_W-1:0] OPC_RRR   = 6'b000000;
  localparam logic [OP_W-1:0] OPC_JMP   = 6'b000010;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE = 6'b101011;

  localparam int unsigned UA_FETCH  = 0;
  localparam int unsigned UA_DECODE = 1;
  localparam int unsigned UA_MADDR  = 2;
  localparam int unsigned UA_LDRD   = 3;
  localparam int unsigned UA_LDWB   = 4;
  localparam int unsigned UA_STWR   = 5;
  localparam int unsigned UA_RREX   = 6;
  localparam int unsigned UA_RRWB   = 7;
  localparam int unsigned UA_BRCMP  = 8;
  localparam int unsigned UA_JMPC   = 9;

endpackage

// File: rtl/ucseq_store.sv
module ucseq_store
  import ucseq_pkg::*;
#(
  parameter int unsigned UA_W = 4
) (
  input  logic [UA_W-1:0] addr,
  output uword_t          word
);

  always_comb begin
    word = '{alu: ALU_ADD, opa_reg: 1'b0, opb: OPB_REGB, rf: RF_IDLE,
             mm: MM_IDLE, pcu: PCU_HOLD, seq: SEQ_FETCH};
    case (int'(addr))
      UA_FETCH: begin
        word.opb = OPB_FOUR;
        word.mm  = MM_RDPC;
        word.pcu = PCU_ALU;
        word.seq = SEQ_STEP;
      end
      UA_DECODE: begin
        word.opb = OPB_IMMSH;
        word.rf  = RF_READ;
        word.seq = SEQ_TBL1;
      end
      UA_MADDR: begin
        word.opa_reg = 1'b1;
        word.opb     = OPB_IMM;
        word.seq     = SEQ_TBL2;
      end
      UA_LDRD: begin
        word.mm  = MM_RDALU;
        word.seq = SEQ_STEP;
      end
      UA_LDWB:  word.rf = RF_WRMDR;
      UA_STWR:  word.mm = MM_WRALU;
      UA_RREX: begin
        word.alu     = ALU_FUNC;
        word.opa_reg = 1'b1;
        word.seq     = SEQ_STEP;
      end
      UA_RRWB:  word.rf = RF_WRALU;
      UA_BRCMP: begin
        word.alu     = ALU_SUB;
        word.opa_reg = 1'b1;
        word.pcu     = PCU_COND;
      end
      UA_JMPC:  word.pcu = PCU_JUMP;
      default:  word.seq = SEQ_FETCH;
    endcase
  end

endmodule

// File: rtl/ucseq_dispatch.sv
module ucseq_dispatch
  import ucseq_pkg::*;
#(
  parameter int unsigned UA_W  = 4,
  parameter int unsigned TABLE = 1
) (
  input  logic [OP_W-1:0] opcode,
  output logic [UA_W-1:0] target
);

  generate
    if (TABLE == 1) begin : g_class
      always_comb begin
        case (opcode)
          OPC_RRR:   target = UA_W'(UA_RREX);
          OPC_JMP:   target = UA_W'(UA_JMPC);
          OPC_BEQ:   target = UA_W'(UA_BRCMP);
          OPC_LOAD,
          OPC_STORE: target = UA_W'(UA_MADDR);
          default:   target = UA_W'(UA_FETCH);
        endcase
      end
    end else begin : g_memsplit
      always_comb begin
        case (opcode)
          OPC_LOAD:  target = UA_W'(UA_LDRD);
          OPC_STORE: target = UA_W'(UA_STWR);
          default:   target = UA_W'(UA_FETCH);
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/ucseq_field_decode.sv
module ucseq_field_decode
  import ucseq_pkg::*;
(
  input  uword_t     word,
  output logic       pc_write,
  output logic       pc_write_cond,
  output logic [1:0] pc_source,
  output logic       iord,
  output logic       mem_read,
  output logic       mem_write,
  output logic       ir_write,
  output logic       reg_write,
  output logic       reg_dst,
  output logic       mem_to_reg,
  output logic       alu_src_a,
  output logic [1:0] alu_src_b,
  output logic [1:0] alu_op
);

  always_comb begin
    alu_op    = word.alu;
    alu_src_a = word.opa_reg;
    alu_src_b = word.opb;
  end

  always_comb begin
    reg_write  = 1'b0;
    reg_dst    = 1'b0;
    mem_to_reg = 1'b0;
    case (word.rf)
      RF_WRALU: begin reg_write = 1'b1; reg_dst = 1'b1; end
      RF_WRMDR: begin reg_write = 1'b1; mem_to_reg = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    mem_read  = 1'b0;
    mem_write = 1'b0;
    iord      = 1'b0;
    ir_write  = 1'b0;
    case (word.mm)
      MM_RDPC:  begin mem_read = 1'b1; ir_write = 1'b1; end
      MM_RDALU: begin mem_read = 1'b1; iord = 1'b1; end
      MM_WRALU: begin mem_write = 1'b1; iord = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    pc_write      = 1'b0;
    pc_write_cond = 1'b0;
    pc_source     = 2'b00;
    case (word.pcu)
      PCU_ALU:  pc_write = 1'b1;
      PCU_COND: begin pc_write_cond = 1'b1; pc_source = 2'b01; end
      PCU_JUMP: begin pc_write = 1'b1; pc_source = 2'b10; end
      default: ;
    endcase
  end

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucseq_pkg::*;
#(
  parameter int unsigned UA_W  = 4,
  parameter int unsigned DEPTH = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [5:0]      opcode,
  output logic [UA_W-1:0] uaddr,
  output logic            pc_write,
  output logic            pc_write_cond,
  output logic [1:0]      pc_source,
  output logic            iord,
  output logic            mem_read,
  output logic            mem_write,
  output logic            ir_write,
  output logic            reg_write,
  output logic            reg_dst,
  output logic            mem_to_reg,
  output logic            alu_src_a,
  output logic [1:0]      alu_src_b,
  output logic [1:0]      alu_op
);

  localparam logic [UA_W-1:0] LAST_UA = UA_W'(DEPTH - 1);

  logic [UA_W-1:0] upc_q;
  logic [UA_W-1:0] upc_nxt;
  logic [UA_W-1:0] upc_inc;
  logic [UA_W-1:0] tgt_tbl1;
  logic [UA_W-1:0] tgt_tbl2;
  uword_t          cur_word;

  ucseq_store #(.UA_W(UA_W)) u_store (
    .addr (upc_q),
    .word (cur_word)
  );

  ucseq_dispatch #(.UA_W(UA_W), .TABLE(1)) u_tbl1 (
    .opcode (opcode),
    .target (tgt_tbl1)
  );

  ucseq_dispatch #(.UA_W(UA_W), .TABLE(2)) u_tbl2 (
    .opcode (opcode),
    .target (tgt_tbl2)
  );

  ucseq_field_decode u_decode (
    .word          (cur_word),
    .pc_write      (pc_write),
    .pc_write_cond (pc_write_cond),
    .pc_source     (pc_source),
    .iord          (iord),
    .mem_read      (mem_read),
    .mem_write     (mem_write),
    .ir_write      (ir_write),
    .reg_write     (reg_write),
    .reg_dst       (reg_dst),
    .mem_to_reg    (mem_to_reg),
    .alu_src_a     (alu_src_a),
    .alu_src_b     (alu_src_b),
    .alu_op        (alu_op)
  );

  // Next-microaddress selection
  always_comb begin
    upc_inc = upc_q + UA_W'(1);
    case (cur_word.seq)
      SEQ_FETCH: upc_nxt = '0;
      SEQ_TBL1:  upc_nxt = tgt_tbl1;
      SEQ_TBL2:  upc_nxt = tgt_tbl2;
      default:   upc_nxt = upc_inc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc_q <= '0;
    else        upc_q <= upc_nxt;
  end

  assign uaddr = upc_q;

  // R2: the microaddress never leaves the populated store
  assert_uaddr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upc_q <= LAST_UA);

  // R2: fetch steps into decode
  assert_fetch_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_q == UA_W'(UA_FETCH)) |=> (upc_q == UA_W'(UA_DECODE)));

  // R3: branch opcode at decode lands on the compare word
  assert_tbl1_branch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_q == UA_W'(UA_DECODE) && opcode == OPC_BEQ) |=> (upc_q == UA_W'(UA_BRCMP)));

  // R4: address routine only splits into load, store or fetch
  assert_tbl2_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_q == UA_W'(UA_MADDR)) |=>
      (upc_q == UA_W'(UA_LDRD) || upc_q == UA_W'(UA_STWR) || upc_q == UA_W'(UA_FETCH)));

  // R5: terminal words return to fetch
  assert_tail_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upc_q == UA_W'(UA_LDWB) || upc_q == UA_W'(UA_STWR) || upc_q == UA_W'(UA_RRWB) ||
     upc_q == UA_W'(UA_BRCMP) || upc_q == UA_W'(UA_JMPC)) |=> (upc_q == '0));

  // R8: memory is never read and written in the same cycle
  assert_mem_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_read, mem_write}));

  // R10: at most one kind of PC update per cycle
  assert_pc_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_write, pc_write_cond}));

endmodule

// File: tb/tb_ucode_sequencer.sv
module tb_ucode_sequencer;

  logic       clk;
  logic       rst_n;
  logic [5:0] opcode;
  logic [3:0] uaddr;
  logic       pc_write, pc_write_cond, iord, mem_read, mem_write, ir_write;
  logic       reg_write, reg_dst, mem_to_reg, alu_src_a;
  logic [1:0] pc_source, alu_src_b, alu_op;

  int checks;
  int failures;

  ucode_sequencer dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .uaddr(uaddr),
    .pc_write(pc_write), .pc_write_cond(pc_write_cond), .pc_source(pc_source),
    .iord(iord), .mem_read(mem_read), .mem_write(mem_write), .ir_write(ir_write),
    .reg_write(reg_write), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
    .alu_src_a(alu_src_a), .alu_src_b(alu_src_b), .alu_op(alu_op)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {opcode, path length, five 4-bit microaddresses (first in MSBs)}
  localparam logic [28:0] VEC [6] = '{
    {6'b000000, 3'd4, 4'd0, 4'd1, 4'd6, 4'd7, 4'd0},
    {6'b100011, 3'd5, 4'd0, 4'd1, 4'd2, 4'd3, 4'd4},
    {6'b101011, 3'd4, 4'd0, 4'd1, 4'd2, 4'd5, 4'd0},
    {6'b000100, 3'd3, 4'd0, 4'd1, 4'd8, 4'd0, 4'd0},
    {6'b000010, 3'd3, 4'd0, 4'd1, 4'd9, 4'd0, 4'd0},
    {6'b111111, 3'd2, 4'd0, 4'd1, 4'd0, 4'd0, 4'd0}
  };

  function automatic logic [15:0] mk(logic pw, logic pwc, logic [1:0] pcs, logic io,
                                     logic mr, logic mw, logic irw, logic rw, logic rd,
                                     logic m2r, logic sa, logic [1:0] sb, logic [1:0] op);
    return {pw, pwc, pcs, io, mr, mw, irw, rw, rd, m2r, sa, sb, op};
  endfunction

  // Expected controls per microaddress, from R7..R10
  function automatic logic [15:0] exp_ctl(logic [3:0] a);
    case (a)
      4'd0: return mk(1,0,2'b00,0,1,0,1,0,0,0,0,2'b01,2'b00);
      4'd1: return mk(0,0,2'b00,0,0,0,0,0,0,0,0,2'b11,2'b00);
      4'd2: return mk(0,0,2'b00,0,0,0,0,0,0,0,1,2'b10,2'b00);
      4'd3: return mk(0,0,2'b00,1,1,0,0,0,0,0,0,2'b00,2'b00);
      4'd4: return mk(0,0,2'b00,0,0,0,0,1,0,1,0,2'b00,2'b00);
      4'd5: return mk(0,0,2'b00,1,0,1,0,0,0,0,0,2'b00,2'b00);
      4'd6: return mk(0,0,2'b00,0,0,0,0,0,0,0,1,2'b00,2'b10);
      4'd7: return mk(0,0,2'b00,0,0,0,0,1,1,0,0,2'b00,2'b00);
      4'd8: return mk(0,1,2'b01,0,0,0,0,0,0,0,1,2'b00,2'b01);
      4'd9: return mk(1,0,2'b10,0,0,0,0,0,0,0,0,2'b00,2'b00);
      default: return 16'h0;
    endcase
  endfunction

  function automatic string req_of(logic [3:0] a);
    case (a)
      4'd0, 4'd1: return "R7";
      4'd2, 4'd3, 4'd4, 4'd5: return "R8";
      4'd6, 4'd7: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [15:0] act_ctl();
    return {pc_write, pc_write_cond, pc_source, iord, mem_read, mem_write, ir_write,
            reg_write, reg_dst, mem_to_reg, alu_src_a, alu_src_b, alu_op};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state(string req, logic [3:0] a);
    check(req, 32'(uaddr), 32'(a));
    check(req_of(a), 32'(act_ctl()), 32'(exp_ctl(a)));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    opcode = 6'b000000;
    repeat (3) @(negedge clk);
    // R1: reset state and fetch controls during reset
    check_state("R1", 4'd0);
    rst_n = 1'b1;

    // Table walk: R2 R3 R4 R5 R6 and per-word controls
    for (int v = 0; v < 6; v++) begin
      logic [5:0]  op;
      logic [2:0]  len;
      logic [19:0] path;
      {op, len, path} = VEC[v];
      opcode = op;
      for (int k = 0; k < int'(len); k++) begin
        check_state((k == 2) ? "R3" : "R2", path[19-4*k -: 4]);
        @(negedge clk);
      end
      // R5 / R6: every routine, including an opcode missing from table 1, returns to fetch
      check_state((v == 5) ? "R6" : "R5", 4'd0);
    end

    // R6: miss in table 2 (opcode changed at the address routine)
    opcode = 6'b100011;
    @(negedge clk);
    @(negedge clk);
    check_state("R4", 4'd2);
    opcode = 6'b000100;
    @(negedge clk);
    check_state("R6", 4'd0);

    // R11: opcode changes at non-dispatch addresses have no effect
    opcode = 6'b111111;
    @(negedge clk);
    check_state("R11", 4'd1);
    opcode = 6'b000100;
    @(negedge clk);
    check_state("R11", 4'd8);
    @(negedge clk);
    opcode = 6'b100011;
    repeat (3) @(negedge clk);
    check_state("R4", 4'd3);
    opcode = 6'b101011;
    @(negedge clk);
    check_state("R11", 4'd4);
    opcode = 6'b000000;
    @(negedge clk);
    check_state("R11", 4'd0);

    // R1: asynchronous reset from inside a routine
    @(negedge clk);
    @(negedge clk);
    check_state("R9", 4'd6);
    #1 rst_n = 1'b0;
    #0.5;
    check("R1", 32'(uaddr), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1", 4'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule